// File: doc/BRIEF.md
# Pin Change Monitor

This block watches the upper four pins of an 8-bit port and raises a change flag when a watched input pin no longer matches a baseline. The baseline is a copy of the watched pin levels. That copy is refreshed whenever the port is read or written. It is not the level seen on the previous clock cycle. Pins whose direction bit marks them as outputs take no part in the comparison. The lower pins of the port are never watched.

The flag is sticky. Software ends a change event in two steps. First it accesses the port, which moves the baseline to the present levels. Then it pulses the clear strobe. A clear that arrives while a mismatch is still present is overridden, so the flag stays set. The interrupt request is the flag gated by an enable bit. The wake request is the flag without gating and is meant for logic that brings the system out of sleep.

After reset the baseline loads the pin levels present at the first clock edge. Pins held away from zero through reset therefore do not raise the flag.

Top module: `pin_change_monitor`

## Requirements
- R1: Only port bits 7 to 4 are watched. A change on bits 3 to 0 never sets the flag.
- R2: When a watched input pin differs from the baseline, the flag is set at the next rising clock edge.
- R3: A direction bit of 1 marks its pin as an input. A watched pin whose direction bit is 0 is left out of the comparison.
- R4: Once set, the flag stays set until a clear strobe arrives in a cycle with no mismatch.
- R5: When the clear strobe and a mismatch occur in the same cycle, the flag stays set.
- R6: A read strobe or a write strobe copies the watched pin levels into the baseline at the clock edge. In that access cycle the pins are still compared against the old baseline.
- R7: `irq_o` is high exactly when the flag is set and `irq_en_i` is high. It follows `irq_en_i` without delay.
- R8: `wake_o` is equal to the flag at all times.
- R9: Reset clears the flag asynchronously. The baseline takes the pin levels present at the first clock edge after reset, so levels held through reset raise no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Synchronized pin levels of the port |
| dir_i | input | 8 | Direction bits, 1 = input, 0 = output |
| rd_stb_i | input | 1 | Port read strobe |
| wr_stb_i | input | 1 | Port write strobe |
| clr_i | input | 1 | Flag clear strobe |
| irq_en_i | input | 1 | Interrupt enable |
| flag_o | output | 1 | Sticky change flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
The stimulus toggles the lower pins alone, which tells a narrowed watch window apart from a full-port comparison. It raises a watched pin whose direction bit is 0, then sets that direction bit to 1, which tests the output mask on its own. It returns a pin to its baseline level with no port access in between; the flag only clears in that case if the comparison uses the access baseline and not the previous-cycle level. The clear strobe is applied with the mismatch held, after a read, after a write, and together with a write, which exposes any error in set-versus-clear priority or in when the baseline is updated. Pins held at a non-zero level through reset, followed by a drop to zero, show that the baseline loads at the first edge after reset.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int unsigned PCM_PORT_W  = 8;
  localparam int unsigned PCM_WATCH_W = 4;
endpackage

// File: rtl/pcm_snapshot.sv
module pcm_snapshot #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  input  logic         capture_i,
  output logic [W-1:0] snap_o,
  output logic         primed_o
);
  logic [W-1:0] snap_q;
  logic         primed_q;

  // first edge after reset seeds the baseline from the live pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      if (!primed_q || capture_i) snap_q <= pins_i;
      primed_q <= 1'b1;
    end
  end

  assign snap_o   = snap_q;
  assign primed_o = primed_q;

  // R6
  snap_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (snap_q == $past(pins_i)));

  // R9
  snap_prime_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_q |=> (primed_q && snap_q == $past(pins_i)));
endmodule

// File: rtl/pcm_compare.sv
module pcm_compare #(
  parameter int unsigned W = 4
) (
  input  logic         armed_i,
  input  logic [W-1:0] pins_i,
  input  logic [W-1:0] snap_i,
  input  logic [W-1:0] is_in_i,
  output logic         mismatch_o
);
  logic [W-1:0] hit;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign hit[g] = is_in_i[g] & (pins_i[g] ^ snap_i[g]);
  end

  assign mismatch_o = armed_i & (|hit);
endmodule

// File: rtl/pcm_flag.sv
module pcm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mismatch_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (mismatch_i) flag_q <= 1'b1;
    else if (clr_i)      flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R2
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_i |=> flag_q);

  // R4
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);

  // R5
  flag_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mismatch_i && clr_i) |=> flag_q);

  // R4
  flag_no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !mismatch_i) |=> !flag_q);
endmodule

// File: rtl/pin_change_monitor.sv
module pin_change_monitor
  import pcm_pkg::*;
#(
  parameter int unsigned PORT_W  = PCM_PORT_W,
  parameter int unsigned WATCH_W = PCM_WATCH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] pin_i,
  input  logic [PORT_W-1:0] dir_i,
  input  logic              rd_stb_i,
  input  logic              wr_stb_i,
  input  logic              clr_i,
  input  logic              irq_en_i,
  output logic              flag_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int unsigned WatchLsb = PORT_W - WATCH_W;

  logic [WATCH_W-1:0] w_pins, w_dir, snap;
  logic               primed, mismatch, flag;

  assign w_pins = pin_i[PORT_W-1:WatchLsb];
  assign w_dir  = dir_i[PORT_W-1:WatchLsb];

  if (WatchLsb > 0) begin : g_lo
    logic unused_lo;
    assign unused_lo = ^{pin_i[WatchLsb-1:0], dir_i[WatchLsb-1:0]};
  end

  pcm_snapshot #(.W(WATCH_W)) i_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pins_i   (w_pins),
    .capture_i(rd_stb_i | wr_stb_i),
    .snap_o   (snap),
    .primed_o (primed)
  );

  pcm_compare #(.W(WATCH_W)) i_cmp (
    .armed_i   (primed),
    .pins_i    (w_pins),
    .snap_i    (snap),
    .is_in_i   (w_dir),
    .mismatch_o(mismatch)
  );

  pcm_flag i_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mismatch_i(mismatch),
    .clr_i     (clr_i),
    .flag_o    (flag)
  );

  assign flag_o = flag;
  assign wake_o = flag;
  assign irq_o  = flag & irq_en_i;

  // R3
  out_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_dir == '0 && !flag_o) |=> !flag_o);

  // R9
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed |=> !flag_o);

  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (wake_o && irq_en_i));
endmodule

// File: tb/test_pin_change_monitor.sv
`timescale 1ns/1ps
module test_pin_change_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = 8'hF0, dir = 8'hFF;
  logic       rd = 1'b0, wr = 1'b0, clr = 1'b0, en = 1'b1;
  logic       flag, irq, wake;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pin_change_monitor i_pin_change_monitor (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .dir_i(dir),
    .rd_stb_i(rd), .wr_stb_i(wr), .clr_i(clr), .irq_en_i(en),
    .flag_o(flag), .irq_o(irq), .wake_o(wake)
  );

  // {req, pin, dir, rd, wr, clr, en, exp_flag, exp_irq}
  localparam int NV = 21;
  localparam logic [25:0] VEC [NV] = '{
    {4'd1, 8'h00, 8'hFF, 4'b0001, 2'b00}, // R1 quiet
    {4'd2, 8'h10, 8'hFF, 4'b0001, 2'b11}, // R2 bit4 rises
    {4'd5, 8'h10, 8'hFF, 4'b0011, 2'b11}, // R5 clear vs mismatch
    {4'd6, 8'h10, 8'hFF, 4'b1001, 2'b11}, // R6 read, old baseline
    {4'd5, 8'h10, 8'hFF, 4'b0011, 2'b00}, // R5 clear after access
    {4'd1, 8'h11, 8'hFF, 4'b0001, 2'b00}, // R1 low bit ignored
    {4'd3, 8'h31, 8'hDF, 4'b0001, 2'b00}, // R3 output masked
    {4'd3, 8'h31, 8'hFF, 4'b0001, 2'b11}, // R3 now input
    {4'd7, 8'h31, 8'hFF, 4'b0100, 2'b10}, // R7 write, irq off
    {4'd7, 8'h31, 8'hFF, 4'b0010, 2'b00},
    {4'd7, 8'h31, 8'hFF, 4'b0001, 2'b00},
    {4'd2, 8'h71, 8'hFF, 4'b0001, 2'b11}, // R2 bit6
    {4'd5, 8'h71, 8'hFF, 4'b0011, 2'b11}, // R5
    {4'd6, 8'h31, 8'hFF, 4'b0011, 2'b00}, // R6 back to baseline
    {4'd6, 8'h31, 8'hFF, 4'b0001, 2'b00},
    {4'd3, 8'hB1, 8'h7F, 4'b0001, 2'b00}, // R3 bit7 output
    {4'd3, 8'hB1, 8'hFF, 4'b0001, 2'b11},
    {4'd4, 8'hB1, 8'hFF, 4'b1001, 2'b11}, // R4
    {4'd4, 8'hB1, 8'hFF, 4'b0001, 2'b11}, // R4 sticky
    {4'd4, 8'hB1, 8'hFF, 4'b0011, 2'b00},
    {4'd6, 8'hB1, 8'hFF, 4'b0111, 2'b00}  // R6 write with clear
  };

  task automatic chk(input int req, input logic ef, input logic ei);
    checks++;
    if (flag !== ef || irq !== ei || wake !== ef) begin
      errors++;
      $display("FAIL R%0d flag/irq/wake=%b%b%b expected %b%b%b",
               req, flag, irq, wake, ef, ei, ef);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9 pins high through reset
    repeat (3) @(posedge clk);
    #1 chk(9, 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    step(); chk(9, 1'b0, 1'b0);
    step(); chk(9, 1'b0, 1'b0);
    @(negedge clk) pin = 8'h00;
    step(); chk(9, 1'b1, 1'b1);            // R9 baseline was F0
    @(negedge clk) rd = 1'b1;
    step(); chk(6, 1'b1, 1'b1);
    @(negedge clk) begin rd = 1'b0; clr = 1'b1; end
    step(); chk(5, 1'b0, 1'b0);
    // R7 irq follows enable combinationally
    @(negedge clk) begin clr = 1'b0; pin = 8'h80; end
    step(); chk(2, 1'b1, 1'b1);
    @(negedge clk) en = 1'b0;
    #1 chk(7, 1'b1, 1'b0);
    @(negedge clk) begin pin = 8'h00; en = 1'b1; clr = 1'b1; end
    step(); chk(8, 1'b0, 1'b0);            // R8 back to baseline
    @(negedge clk) clr = 1'b0;
    step();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pin = VEC[i][21:14];
      dir = VEC[i][13:6];
      {rd, wr, clr, en} = VEC[i][5:2];
      step();
      chk(int'(VEC[i][25:22]), VEC[i][1], VEC[i][0]);
    end

    // R9 async reset clears a set flag mid-cycle
    @(negedge clk) begin {rd, wr, clr, en} = 4'b0001; pin = 8'h01; end
    step(); chk(2, 1'b1, 1'b1);
    #1 rst_n = 1'b0;
    #0.5 chk(9, 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    step(); chk(9, 1'b0, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule